// File: doc/BRIEF.md
# Scan Pacing and Timing Controller

This block runs multichannel acquisition scans. A scan begins on a scan-clock tick or on a start request, but only when the pacer gate is inactive. Once a scan begins, the block issues one single-cycle convert pulse for each programmed channel, spaced by a programmable interval. Around those pulses it drives the scan strobes:

- a start-of-scan pulse;
- a sample-hold level that spans the scan up to its last conversion;
- an end-of-scan pulse;
- a multiplexer-advance pulse after every convert, for stepping an external input multiplexer.

The pacer gate is sampled only when a scan would begin. A gate that turns active in the middle of a scan lets that scan run to completion and then blocks further scans until the gate is released. The gate polarity is selectable. A trigger that arrives while a scan is running is dropped and latched in a sticky overrun flag.

The channel count and the convert interval are captured when a scan begins. The block leaves the converter, the channel list storage and the host interface to surrounding logic.

Top module: `scan_pacer`

## Requirements
- R1: While rst_ni is low, and after it is released until a trigger arrives, every output is 0. A reset applied in the middle of a scan aborts the scan and clears the overrun flag.
- R2: A trigger (scan_tick_i high) is sampled at a clock edge while the block is idle and the gate is inactive. In the first cycle after that edge, scan_start_o and conv_o are both high for that one cycle, and busy_o is high.
- R3: A scan issues exactly N convert pulses, each one cycle long, G cycles apart. N is num_ch_i, with 0 treated as 1 and values above 16 treated as 16.
- R4: The interval G is conv_gap_i, except that a value below 18 is treated as 18.
- R5: hold_o rises with the first convert and falls in the cycle of the last convert. For N = 1 it never rises.
- R6: scan_end_o is a one-cycle pulse N·G cycles after the first convert. In that cycle busy_o is low, and a trigger sampled at the end of that cycle begins the next scan.
- R7: After each convert pulse in cycle C, mux_adv_o is high from cycle C+2 through cycle C+17 (16 cycles), and low otherwise.
- R8: A trigger sampled while the gate is active starts no scan and does not set overrun_o.
- R9: If the gate turns active during a scan, that scan still completes with all N converts and its end pulse. No scan then starts until the gate is released.
- R10: With gate_act_low_i = 0 the gate is active when gate_i = 1. With gate_act_low_i = 1 it is active when gate_i = 0.
- R11: A trigger sampled while busy_o is high does not alter the running scan. It sets overrun_o, which stays high until reset.
- R12: start_req_i acts as a trigger in exactly the same way as scan_tick_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_tick_i | input | 1 | Scan-clock tick, one cycle |
| start_req_i | input | 1 | Start request, one cycle |
| num_ch_i | input | CH_W (5) | Channel count per scan |
| conv_gap_i | input | GAP_W (8) | Cycles between convert pulses |
| gate_i | input | 1 | Pacer gate level |
| gate_act_low_i | input | 1 | 1 selects an active-low gate |
| conv_o | output | 1 | Convert pulse |
| scan_start_o | output | 1 | Start-of-scan pulse |
| hold_o | output | 1 | Sample-hold level |
| scan_end_o | output | 1 | End-of-scan pulse |
| mux_adv_o | output | 1 | Delayed multiplexer-advance pulse |
| busy_o | output | 1 | Scan in progress |
| overrun_o | output | 1 | Sticky flag for a dropped trigger |

## Verification
The bench uses the default parameters: up to 16 channels, an 8-bit interval, and an advance pulse with a 2-cycle delay and a 16-cycle width. The 5-bit count port can carry 0 and values above 16, and the 8-bit interval port can carry values below the 18-cycle floor, so both clamps are exercised at the ports. Every scan is compared cycle by cycle against a model built from N and G. The tests cover:

- the minimum interval, where advance pulses sit two cycles apart;
- back-to-back scans triggered in the end-pulse cycle;
- gate changes in the middle of a scan under both polarities.

// File: rtl/scan_pacer_pkg.sv
package scan_pacer_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/scan_cfg_clamp.sv
module scan_cfg_clamp #(
  parameter int MAX_CH  = 16,
  parameter int CH_W    = 5,
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 18
) (
  input  logic [CH_W-1:0]  num_ch_i,
  input  logic [GAP_W-1:0] conv_gap_i,
  output logic [CH_W-1:0]  ch_o,
  output logic [GAP_W-1:0] gap_o
);
  always_comb begin
    if (num_ch_i == '0)                  ch_o = CH_W'(1);
    else if (num_ch_i > CH_W'(MAX_CH))   ch_o = CH_W'(MAX_CH);
    else                                 ch_o = num_ch_i;
  end

  // interval floor keeps advance pulses of neighbouring converts apart
  assign gap_o = (conv_gap_i < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : conv_gap_i;
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pacer_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             gate_act_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             conv_o,
  output logic             start_o,
  output logic             hold_o,
  output logic             end_o,
  output logic             busy_o,
  output logic             overrun_o
);
  seq_state_e       state_q;
  logic [CH_W-1:0]  ch_left_q;
  logic [GAP_W-1:0] gap_cnt_q;
  logic [GAP_W-1:0] gap_q;

  assign busy_o = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ch_left_q <= '0;
      gap_cnt_q <= '0;
      gap_q     <= '0;
      conv_o    <= 1'b0;
      start_o   <= 1'b0;
      hold_o    <= 1'b0;
      end_o     <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      conv_o  <= 1'b0;
      start_o <= 1'b0;
      end_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          // gate is sampled only here, so a running scan always completes
          if (trig_i && !gate_act_i) begin
            state_q   <= ST_RUN;
            conv_o    <= 1'b1;
            start_o   <= 1'b1;
            hold_o    <= (ch_i != CH_W'(1));
            ch_left_q <= ch_i - CH_W'(1);
            gap_q     <= gap_i;
            gap_cnt_q <= gap_i - GAP_W'(1);
          end
        end
        ST_RUN: begin
          if (trig_i) overrun_o <= 1'b1;
          if (gap_cnt_q != '0) begin
            gap_cnt_q <= gap_cnt_q - GAP_W'(1);
          end else if (ch_left_q != '0) begin
            conv_o    <= 1'b1;
            ch_left_q <= ch_left_q - CH_W'(1);
            gap_cnt_q <= gap_q - GAP_W'(1);
            if (ch_left_q == CH_W'(1)) hold_o <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
            end_o   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_start_with_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (conv_o && busy_o));
  a_r3_conv_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> busy_o);
  a_r3_conv_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o);
  a_r5_hold_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> (conv_o && ch_left_q == '0));
  a_r6_end_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> (!busy_o && !hold_o && !conv_o));
  a_r8_gate_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && gate_act_i) |=> !start_o);
  a_r11_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: rtl/mux_adv_gen.sv
module mux_adv_gen #(
  parameter int ADV_DLY = 2,
  parameter int ADV_WID = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_i,
  output logic adv_o
);
  localparam int CNT_W = $clog2(ADV_WID + 1);

  logic             load;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (ADV_DLY <= 1) begin : g_no_pipe
      assign load = conv_i;
    end else begin : g_pipe
      logic [ADV_DLY-2:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q, conv_i};
      end
      assign load = pipe_q[ADV_DLY-2];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load)         cnt_q <= CNT_W'(ADV_WID);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign adv_o = (cnt_q != '0);

  a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> (cnt_q == '0));
  a_r7_rise_after_pipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adv_o) |-> $past(load));
endmodule

// File: rtl/scan_pacer.sv
module scan_pacer #(
  parameter int MAX_CH  = 16,
  parameter int GAP_W   = 8,
  parameter int ADV_DLY = 2,
  parameter int ADV_WID = 16,
  localparam int CH_W    = $clog2(MAX_CH + 1),
  localparam int MIN_GAP = ADV_DLY + ADV_WID
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_tick_i,
  input  logic             start_req_i,
  input  logic [CH_W-1:0]  num_ch_i,
  input  logic [GAP_W-1:0] conv_gap_i,
  input  logic             gate_i,
  input  logic             gate_act_low_i,
  output logic             conv_o,
  output logic             scan_start_o,
  output logic             hold_o,
  output logic             scan_end_o,
  output logic             mux_adv_o,
  output logic             busy_o,
  output logic             overrun_o
);
  logic [CH_W-1:0]  ch_eff;
  logic [GAP_W-1:0] gap_eff;
  logic             gate_act;
  logic             trig;

  assign gate_act = gate_i ^ gate_act_low_i;
  assign trig     = scan_tick_i | start_req_i;

  scan_cfg_clamp #(
    .MAX_CH (MAX_CH),
    .CH_W   (CH_W),
    .GAP_W  (GAP_W),
    .MIN_GAP(MIN_GAP)
  ) i_clamp (
    .num_ch_i  (num_ch_i),
    .conv_gap_i(conv_gap_i),
    .ch_o      (ch_eff),
    .gap_o     (gap_eff)
  );

  scan_seq #(
    .CH_W (CH_W),
    .GAP_W(GAP_W)
  ) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig),
    .gate_act_i(gate_act),
    .ch_i      (ch_eff),
    .gap_i     (gap_eff),
    .conv_o    (conv_o),
    .start_o   (scan_start_o),
    .hold_o    (hold_o),
    .end_o     (scan_end_o),
    .busy_o    (busy_o),
    .overrun_o (overrun_o)
  );

  mux_adv_gen #(
    .ADV_DLY(ADV_DLY),
    .ADV_WID(ADV_WID)
  ) i_adv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .conv_i(conv_o),
    .adv_o (mux_adv_o)
  );

  a_r1_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !hold_o);
  a_r10_polarity_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (gate_i != gate_act_low_i)) |=> !scan_start_o);
endmodule

// File: tb/test_scan_pacer.sv
module test_scan_pacer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, req = 1'b0;
  logic [4:0] num_ch = 5'd1;
  logic [7:0] conv_gap = 8'd18;
  logic       gate = 1'b0, pol_low = 1'b0;
  logic       conv, sstart, hold, send, adv, busy, ovr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scan_pacer i_scan_pacer (
    .clk_i(clk), .rst_ni(rst_n), .scan_tick_i(tick), .start_req_i(req),
    .num_ch_i(num_ch), .conv_gap_i(conv_gap), .gate_i(gate),
    .gate_act_low_i(pol_low), .conv_o(conv), .scan_start_o(sstart),
    .hold_o(hold), .scan_end_o(send), .mux_adv_o(adv), .busy_o(busy),
    .overrun_o(ovr)
  );

  task automatic check(string rq, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic set_gate(bit active);
    gate = active ^ pol_low;
  endtask

  function automatic int outs_word();
    return {conv, sstart, hold, send, adv, busy, ovr};
  endfunction

  // begins at a negedge with the block idle; ends at the negedge of the end-pulse cycle
  task automatic run_scan(int n, int g, bit use_req, int gate_at, int tick_at, string tag);
    int ne, ge, last, nconv;
    int e_conv, e_start, e_hold, e_end, e_adv, e_busy;
    ne = (n == 0) ? 1 : (n > 16 ? 16 : n);
    ge = (g < 18) ? 18 : g;
    last = ne * ge;
    nconv = 0; e_conv = 0; e_start = 0; e_hold = 0; e_end = 0; e_adv = 0; e_busy = 0;
    num_ch = 5'(n); conv_gap = 8'(g);
    if (use_req) req = 1'b1; else tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0; req = 1'b0;
    for (int k = 0; k <= last; k++) begin
      bit x_conv, x_adv, x_hold;
      x_conv = (k < last) && (k % ge == 0);
      x_adv  = (k / ge < ne) && (k % ge >= 2) && (k % ge <= 17);
      x_hold = (k < (ne - 1) * ge);
      if (conv) nconv++;
      if (conv !== x_conv) e_conv++;
      if (sstart !== (k == 0)) e_start++;
      if (hold !== x_hold) e_hold++;
      if (send !== (k == last)) e_end++;
      if (adv !== x_adv) e_adv++;
      if (busy !== (k < last)) e_busy++;
      if (k == gate_at) set_gate(1);
      tick = (k == tick_at);
      if (k < last) @(negedge clk);
    end
    tick = 1'b0;
    check("R3", {tag, " convert count"}, nconv, ne);
    check("R3", {tag, " convert timing errors"}, e_conv, 0);
    check("R2", {tag, " start pulse errors"}, e_start, 0);
    check("R2", {tag, " busy errors"}, e_busy, 0);
    check("R5", {tag, " hold errors"}, e_hold, 0);
    check("R6", {tag, " end pulse errors"}, e_end, 0);
    check("R7", {tag, " advance errors"}, e_adv, 0);
  endtask

  // triggers repeatedly; no scan may begin
  task automatic expect_no_scan(int cycles, string rq, string tag);
    int seen = 0;
    for (int k = 0; k < cycles; k++) begin
      tick = (k % 2 == 0);
      @(posedge clk); @(negedge clk);
      if (sstart || busy || conv) seen++;
    end
    tick = 1'b0;
    check(rq, {tag, " scan activity while gated"}, seen, 0);
  endtask

  task automatic test_reset();
    #1;
    check("R1", "outputs during reset", outs_word(), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "outputs after reset release", outs_word(), 0);
  endtask

  task automatic test_basic();
    run_scan(4, 20, 0, -1, -1, "basic");
  endtask

  task automatic test_count_clamp();
    @(negedge clk);
    run_scan(0, 25, 0, -1, -1, "n0 as 1");
    @(negedge clk);
    run_scan(31, 18, 0, -1, -1, "n31 as 16");
  endtask

  task automatic test_gap_clamp();
    @(negedge clk);
    run_scan(3, 5, 0, -1, -1, "R4 gap5 as 18");
    @(negedge clk);
    run_scan(2, 0, 0, -1, -1, "R4 gap0 as 18");
  endtask

  task automatic test_single();
    @(negedge clk);
    run_scan(1, 30, 0, -1, -1, "R5 single channel");
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    run_scan(2, 19, 0, -1, -1, "R6 first");
    run_scan(3, 18, 0, -1, -1, "R6 retrigger in end cycle");
  endtask

  task automatic test_gate_block();
    @(negedge clk);
    set_gate(1);
    expect_no_scan(30, "R8", "gate held");
    check("R8", "overrun after gated triggers", ovr, 0);
    set_gate(0);
    @(negedge clk);
    run_scan(2, 18, 0, -1, -1, "R8 after release");
  endtask

  task automatic test_gate_midscan();
    @(negedge clk);
    run_scan(3, 20, 0, 10, -1, "R9 gate mid scan");
    expect_no_scan(40, "R9", "after gated scan");
    check("R9", "overrun after gated scan", ovr, 0);
    set_gate(0);
    @(negedge clk);
    run_scan(2, 18, 0, -1, -1, "R9 after release");
  endtask

  task automatic test_polarity();
    pol_low = 1'b1;
    set_gate(0);
    @(negedge clk);
    check("R10", "gate_i level with active-low inactive", gate, 1);
    run_scan(2, 18, 0, -1, -1, "R10 low polarity, gate high");
    set_gate(1);
    expect_no_scan(20, "R10", "low polarity, gate low");
    set_gate(0);
    pol_low = 1'b0;
    set_gate(0);
    @(negedge clk);
  endtask

  task automatic test_start_req();
    @(negedge clk);
    run_scan(3, 21, 1, -1, -1, "R12 start request");
  endtask

  task automatic test_overrun();
    @(negedge clk);
    check("R11", "overrun clear before", ovr, 0);
    run_scan(2, 20, 0, -1, 5, "R11 tick mid scan");
    check("R11", "overrun set", ovr, 1);
    @(negedge clk);
    run_scan(1, 18, 0, -1, -1, "R11 next scan");
    check("R11", "overrun sticky", ovr, 1);
  endtask

  task automatic test_reset_mid();
    @(negedge clk);
    num_ch = 5'd4; conv_gap = 8'd20; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (5) @(negedge clk);
    check("R1", "busy before abort", busy, 1);
    rst_n = 1'b0;
    #1;
    check("R1", "outputs after mid-scan reset", outs_word(), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check("R1", "idle after abort", outs_word(), 0);
  endtask

  initial begin
    test_reset();
    test_basic();
    test_count_clamp();
    test_gap_clamp();
    test_single();
    test_back_to_back();
    test_gate_block();
    test_gate_midscan();
    test_polarity();
    test_start_req();
    test_overrun();
    test_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule